// File: doc/BRIEF.md
# Truncating Float-to-Int32 Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer, always rounding toward zero. The operand arrives as a two-bit class code, a sign bit, a signed unbiased exponent and a 32-bit significand whose leading 1 is explicit at bit 31. The block aligns the significand with a right shift it performs itself. Every bit pushed out of the integer field is gathered into a sticky indication, which drives the inexact flag.

Values the integer range cannot hold saturate to a limit chosen by the sign, and raise the invalid flag in place of the inexact flag. Infinity and NaN operands take the same path. Results are registered: an operand presented with `in_valid` in one cycle shows its result, with `out_valid` high, in the next cycle.

Top module: `fp_to_int_trunc`

## Requirements
- R1: While reset is held, and after it is released until the first valid operand, out_valid, out_int, out_inexact and out_invalid are all 0.
- R2: Latency is one clock. out_valid in a cycle equals in_valid of the cycle before. When in_valid is low, out_int and both flags keep their previous values.
- R3: Class encoding is 00 zero, 01 number, 10 infinity, 11 NaN. A zero-class operand yields 0 with no flag set, whatever the sign, exponent and significand are.
- R4: For a number with exponent e from 0 to 30, the magnitude is the top e+1 significand bits (significand shifted right by 31-e). The result is this magnitude, two's-complement negated when the sign is 1.
- R5: When a non-overflowing number loses any nonzero significand bit in the shift, out_inexact is 1. Otherwise it is 0.
- R6: A number with a negative exponent yields 0. out_inexact is 1 exactly when the significand is nonzero, and out_invalid is 0.
- R7: A number with an exponent of 32 or more overflows.
- R8: At exponent 31, a positive number always overflows. A negative number is in range only when its significand is exactly 0x80000000, which gives 0x80000000 with no flag set.
- R9: Infinity and NaN operands overflow, whatever their sign or significand.
- R10: On overflow, out_invalid is 1 and out_inexact is 0. out_int is 0x7FFFFFFF for a positive sign and 0x80000000 for a negative sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 2 | Operand class: 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | 10 | Signed unbiased exponent |
| in_sig | input | 32 | Significand, leading 1 at bit 31 |
| out_valid | output | 1 | Result present this cycle |
| out_int | output | 32 | Two's-complement integer result |
| out_inexact | output | 1 | Nonzero bits were truncated |
| out_invalid | output | 1 | Overflow, infinity or NaN |

## Verification
The hardest case to reach is the border of the range at exponent 31. Only a negative sign paired with a significand of exactly 0x80000000 stays legal there, and a random significand almost never produces it. The stimulus therefore aims at this border on purpose. It sends that exact pattern with both signs, the same significand plus one low bit with a negative sign, and all-ones significands at exponents 30 and 31. It also sends very negative exponents, and exponents just below and at 32. Random operands, with exponents spread around the legal window, then fill in the shift amounts between these points.

// File: rtl/fti_pkg.sv
package fti_pkg;

    typedef enum logic [1:0] {
        FTI_ZERO = 2'b00,
        FTI_NUM  = 2'b01,
        FTI_INF  = 2'b10,
        FTI_NAN  = 2'b11
    } fti_class_e;

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
        logic        inexact;
        logic        invalid;
    } fti_out_t;

endpackage

// File: rtl/fti_align.sv
// Right-aligns the significand so that its integer part sits at the bottom.
// Bits shifted out are ORed into a sticky indication, stage by stage.
module fti_align #(
    parameter int W     = 32,
    parameter int EXP_W = 10
) (
    input  logic [W-1:0]            sig,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic [W-1:0]            mag,
    output logic                    sticky,
    output logic                    too_big
);
    localparam int SHW = $clog2(W);

    logic             neg_exp;
    logic [SHW-1:0]   amt;
    logic [W-1:0]     stg [0:SHW];
    logic             stk [0:SHW];

    assign neg_exp = exp_in[EXP_W-1];
    assign too_big = (exp_in >= $signed(EXP_W'(W)));
    assign amt     = SHW'(W-1) - exp_in[SHW-1:0];

    assign stg[0] = sig;
    assign stk[0] = 1'b0;

    generate
        for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stg[k+1] = amt[k] ? (stg[k] >> SH) : stg[k];
            assign stk[k+1] = stk[k] | (amt[k] & (|stg[k][SH-1:0]));
        end
    endgenerate

    assign mag    = neg_exp ? '0 : stg[SHW];
    assign sticky = neg_exp ? (|sig) : stk[SHW];
endmodule

// File: rtl/fti_pack.sv
// Range check, sign application and saturation.
module fti_pack #(
    parameter int W = 32
) (
    input  fti_pkg::fti_class_e cls,
    input  logic                sign,
    input  logic [W-1:0]        mag,
    input  logic                sticky,
    input  logic                too_big,
    output logic [W-1:0]        result,
    output logic                inexact,
    output logic                invalid
);
    import fti_pkg::*;

    logic mag_ovf;
    logic ovf;

    // Magnitude 2^(W-1) is legal only for a negative operand.
    assign mag_ovf = mag[W-1] & (~sign | (|mag[W-2:0]));

    always_comb begin
        ovf = 1'b0;
        unique case (cls)
            FTI_ZERO: ovf = 1'b0;
            FTI_NUM:  ovf = too_big | mag_ovf;
            default:  ovf = 1'b1;
        endcase
    end

    always_comb begin
        result  = '0;
        inexact = 1'b0;
        invalid = 1'b0;
        if (ovf) begin
            invalid = 1'b1;
            result  = sign ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else if (cls == FTI_NUM) begin
            inexact = sticky;
            result  = sign ? (~mag + W'(1)) : mag;
        end
    end
endmodule

// File: rtl/fp_to_int_trunc.sv
module fp_to_int_trunc #(
    parameter int W     = 32,
    parameter int EXP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [W-1:0]            in_sig,
    output logic                    out_valid,
    output logic [W-1:0]            out_int,
    output logic                    out_inexact,
    output logic                    out_invalid
);
    import fti_pkg::*;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
        logic         inexact;
        logic         invalid;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] mag;
    logic         sticky;
    logic         too_big;
    logic [W-1:0] res;
    logic         nx;
    logic         nv;

    fti_align #(.W(W), .EXP_W(EXP_W)) align_i (
        .sig     (in_sig),
        .exp_in  (in_exp),
        .mag     (mag),
        .sticky  (sticky),
        .too_big (too_big)
    );

    fti_pack #(.W(W)) pack_i (
        .cls     (fti_class_e'(in_class)),
        .sign    (in_sign),
        .mag     (mag),
        .sticky  (sticky),
        .too_big (too_big),
        .result  (res),
        .inexact (nx),
        .invalid (nv)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.data    = res;
            st_d.inexact = nx;
            st_d.invalid = nv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_int     = st_q.data;
    assign out_inexact = st_q.inexact;
    assign out_invalid = st_q.invalid;
endmodule

// File: rtl/fti_checker.sv
module fti_checker #(
    parameter int W     = 32,
    parameter int EXP_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [1:0]              in_class,
    input logic signed [EXP_W-1:0] in_exp,
    input logic                    out_valid,
    input logic [W-1:0]            out_int,
    input logic                    out_inexact,
    input logic                    out_invalid
);
    localparam logic [W-1:0] POS_SAT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_SAT = {1'b1, {(W-1){1'b0}}};

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_int) && $stable(out_invalid)));

    a_r3_zero_class: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'b00) |=> (out_int == '0 && !out_inexact && !out_invalid));

    a_r7_big_exponent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'b01 && in_exp >= $signed(EXP_W'(W))) |=> out_invalid);

    a_r9_special_class: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class[1]) |=> out_invalid);

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (!out_inexact && (out_int == POS_SAT || out_int == NEG_SAT)));
endmodule

bind fp_to_int_trunc fti_checker #(.W(W), .EXP_W(EXP_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .in_exp      (in_exp),
    .out_valid   (out_valid),
    .out_int     (out_int),
    .out_inexact (out_inexact),
    .out_invalid (out_invalid)
);

// File: tb/fp_to_int_trunc_tb_top.sv
module fp_to_int_trunc_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [1:0]        in_class = 2'b00;
    logic              in_sign = 1'b0;
    logic signed [9:0] in_exp = '0;
    logic [31:0]       in_sig = '0;
    logic              out_valid;
    logic [31:0]       out_int;
    logic              out_inexact;
    logic              out_invalid;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    fp_to_int_trunc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
        .out_valid(out_valid), .out_int(out_int),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    // Behavioural reference: arithmetic on wide integers.
    function automatic void model(input logic [1:0] cls, input bit s, input int e,
                                  input logic [31:0] sig, output logic [31:0] r,
                                  output bit nx, output bit nv);
        longint mag, div, lim;
        bit lost;
        r = 0; nx = 0; nv = 0;
        if (cls == 2'b00) return;
        if (cls != 2'b01 || e >= 32) begin
            nv = 1; r = s ? 32'h8000_0000 : 32'h7FFF_FFFF; return;
        end
        if (e < 0) begin
            mag = 0; lost = (sig != 0);
        end else begin
            div  = longint'(1) << (31 - e);
            mag  = longint'(sig) / div;
            lost = (longint'(sig) % div) != 0;
        end
        lim = s ? 64'sd2147483648 : 64'sd2147483647;
        if (mag > lim) begin
            nv = 1; r = s ? 32'h8000_0000 : 32'h7FFF_FFFF; return;
        end
        r  = s ? 32'(-mag) : 32'(mag);
        nx = lost;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    // Drive at a falling edge; result registers at the next rising edge;
    // sample at the following falling edge.
    task automatic apply(input string req, input logic [1:0] cls, input bit s,
                         input int e, input logic [31:0] sig);
        logic [31:0] r; bit nx, nv;
        model(cls, s, e, sig, r, nx, nv);
        @(negedge clk);
        in_valid = 1'b1; in_class = cls; in_sign = s;
        in_exp = 10'(e); in_sig = sig;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "valid", 32'(out_valid), 32'd1);
        check(req, "int", out_int, r);
        check(req, "inexact", 32'(out_inexact), 32'(nx));
        check(req, "invalid", 32'(out_invalid), 32'(nv));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check("R1", "valid", 32'(out_valid), 0);
        check("R1", "int", out_int, 0);
        check("R1", "flags", {30'd0, out_inexact, out_invalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after release", 32'(out_valid), 0);

        apply("R3", 2'b00, 1'b1, 5, 32'hDEAD_BEEF);
        apply("R3", 2'b00, 1'b0, 40, 32'hFFFF_FFFF);
        apply("R4", 2'b01, 1'b0, 0, 32'h8000_0000);
        apply("R4", 2'b01, 1'b1, 3, 32'hE000_0000);
        apply("R4", 2'b01, 1'b0, 30, 32'hFFFF_FFFE);
        apply("R5", 2'b01, 1'b0, 30, 32'hFFFF_FFFF);
        apply("R5", 2'b01, 1'b1, 7, 32'hC0F0_0001);
        apply("R6", 2'b01, 1'b0, -1, 32'h8000_0000);
        apply("R6", 2'b01, 1'b1, -300, 32'hFFFF_FFFF);
        apply("R7", 2'b01, 1'b0, 32, 32'h8000_0000);
        apply("R7", 2'b01, 1'b1, 200, 32'h8000_0000);
        apply("R8", 2'b01, 1'b1, 31, 32'h8000_0000);
        apply("R8", 2'b01, 1'b0, 31, 32'h8000_0000);
        apply("R8", 2'b01, 1'b1, 31, 32'h8000_0001);
        apply("R8", 2'b01, 1'b1, 31, 32'hFFFF_FFFF);
        apply("R9", 2'b10, 1'b0, 0, 32'h8000_0000);
        apply("R9", 2'b11, 1'b1, -3, 32'hC000_0000);
        apply("R10", 2'b10, 1'b1, 300, 32'h8000_0000);

        // R2: idle cycles keep outputs and drop valid
        held = out_int;
        @(negedge clk);
        in_valid = 1'b0; in_class = 2'b01; in_exp = 10'd10; in_sig = 32'h9999_9999;
        @(negedge clk);
        check("R2", "valid low when idle", 32'(out_valid), 0);
        check("R2", "int held when idle", out_int, held);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] c;
            int e;
            c = ($urandom % 8 < 6) ? 2'b01 : 2'($urandom);
            e = int'($urandom % 44) - 6;
            apply("R4", c, 1'($urandom), e, {1'b1, 31'($urandom)});
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule